// File: doc/BRIEF.md
# Store completion tracker

This block keeps, for each of eight in-flight instruction blocks, a record of which memory operations the block declares as stores and which of those stores have already executed somewhere in the memory system. When a block is dispatched, its 32-bit store mask is written into the block's slot. Stores that execute at this bank arrive on the local port. Stores that execute at other banks arrive as short notifications that carry only an operation ID and a slot ID. No address or data goes with them, and no store count is ever needed. A block's stores are finished once every expected bit has been marked. The tracker then raises a one-cycle completion pulse for that slot.

The tracker also answers a combinational ordering query for loads. For a given slot and operation ID, it reports whether every earlier store in the same block, and every store of every older allocated block, has been seen. Each local store is re-broadcast one cycle later so that the peer banks can mark it too. Flush by slot mask and deallocation at commit return slots to the free state. A notification that matches nothing is ignored, and it sets a sticky error flag.

Top module: `store_done_tracker`

## Requirements
- R1: After reset, no slot is allocated, `donePulse` is all zero, `errFlag` and `bcastValid` are 0, and `qryClear` is 0 for every slot.
- R2: A dispatch loads `dispMask` into slot `dispSlot` and clears its arrived record. Bit i set means operation ID i of that block is a store. A slot dispatched with an all-zero mask pulses `donePulse` in the clock cycle after the dispatch edge.
- R3: A local store (`localValid`, `localSlot`, `localOpId`) appears on `bcastValid`/`bcastSlot`/`bcastOpId` one clock later. It also marks that store as arrived in the local record.
- R4: Each of the `NUM_PEERS` peer notification ports marks its (slot, operation ID) as arrived. Any number of ports, together with the local port, may be active in the same cycle.
- R5: `donePulse[s]` is high for exactly one cycle. That cycle starts at the clock edge after the edge that recorded the last outstanding expected store of slot s. A nullified store reaches the tracker through the same ports and counts the same as a real one.
- R6: A slot pulses at most once per dispatch. Repeated notifications for stores already marked raise no new pulse until the slot is dispatched again.
- R7: A flush with `flushMask` bit s set clears slot s completely in one cycle. The slot is then unallocated, gives no pulse, and no longer blocks queries. If a dispatch targets the same slot in the same cycle, the dispatch takes effect.
- R8: A notification to an unallocated slot, or for an operation ID whose mask bit is clear, leaves the store records unchanged. It sets `errFlag`, which stays set until reset.
- R9: A commit (`commitValid`, `commitSlot`) deallocates the slot. The slot then gives no pulse, its queries return 0, and later notifications to it count as errors under R8.
- R10: `qryClear` is 1 only when three conditions hold: `qrySlot` is allocated, every expected store of that slot with an ID below `qryOpId` has arrived, and every allocated slot dispatched before `qrySlot` has all its expected stores arrived. Age is defined by dispatch order.
- R11: Slots are independent. Arrivals for one slot never change the pulse or record of another slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | Block dispatch strobe |
| dispSlot | input | 3 | Slot being dispatched |
| dispMask | input | 32 | Store mask of the dispatched block |
| localValid | input | 1 | Store executed at this bank |
| localSlot | input | 3 | Slot of the local store |
| localOpId | input | 5 | Operation ID of the local store |
| peerValid | input | NUM_PEERS | Per-port peer notification strobe |
| peerSlot | input | 3*NUM_PEERS | Slot ID per peer port, port p at bits [3p+2:3p] |
| peerOpId | input | 5*NUM_PEERS | Operation ID per peer port, port p at bits [5p+4:5p] |
| flushValid | input | 1 | Flush strobe |
| flushMask | input | 8 | Slots to flush, bit s for slot s |
| commitValid | input | 1 | Commit/deallocation strobe |
| commitSlot | input | 3 | Slot being deallocated |
| qrySlot | input | 3 | Slot of the querying load |
| qryOpId | input | 5 | Operation ID of the querying load |
| bcastValid | output | 1 | Registered re-broadcast of a local store |
| bcastSlot | output | 3 | Slot of the re-broadcast store |
| bcastOpId | output | 5 | Operation ID of the re-broadcast store |
| donePulse | output | 8 | One-cycle completion pulse per slot |
| qryClear | output | 1 | All earlier stores seen for the query |
| errFlag | output | 1 | Sticky error for unmatched notifications |

## Verification
Directed sequences cover several cases. Empty masks show that completion needs no arrival at all. Two-store masks completed by local and then peer arrivals separate the two marking paths. When all peer ports fire in the same cycle, an arrival dropped by a port collision becomes visible. A flush that coincides with a dispatch of the same slot checks which of the two wins. Queries against an older pending block and against lower and higher IDs within one block check the two halves of the ordering answer separately. Seeded random traffic then mixes dispatches of sparse masks, arrivals spread over all ports, flushes and commits of finished slots, and every pulse, broadcast and query answer is compared with a bench model that orders blocks by a dispatch sequence number.

// File: rtl/strk_pkg.sv
package strk_pkg;
  localparam int SLOTS  = 8;
  localparam int OPS    = 32;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int OP_W   = $clog2(OPS);

  typedef logic [SLOTS-1:0] slotVec_t;
  typedef logic [OPS-1:0]   opVec_t;

  // Strobes from control to the per-slot store records
  typedef struct packed {
    slotVec_t load;    // write new mask, clear arrivals
    slotVec_t drop;    // clear both vectors (flush or commit)
    slotVec_t markEn;  // slot may accept arrival marks this cycle
  } strobe_t;
endpackage

// File: rtl/strk_data.sv
module strk_data
  import strk_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  opVec_t                 dispMask,
  input  logic [NSRC-1:0]        srcValid,
  input  logic [NSRC*SLOT_W-1:0] srcSlot,
  input  logic [NSRC*OP_W-1:0]   srcOp,
  input  logic [SLOT_W-1:0]      qrySlot,
  input  logic [OP_W-1:0]        qryOp,
  output slotVec_t               slotPending,
  output logic [NSRC-1:0]        srcExpHit,
  output logic                   qryOwnClear
);
  opVec_t expAll [SLOTS];
  opVec_t arrAll [SLOTS];
  logic [SLOTS-1:0][OPS-1:0] markVec;
  opVec_t lowerMask;

  // Decode every arrival source into per-slot bit marks
  always_comb begin
    markVec = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (srcValid[k]) markVec[srcSlot[k*SLOT_W +: SLOT_W]][srcOp[k*OP_W +: OP_W]] = 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    opVec_t expR;
    opVec_t arrR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        expR <= '0;
        arrR <= '0;
      end else if (stb.load[s]) begin
        expR <= dispMask;
        arrR <= '0;
      end else if (stb.drop[s]) begin
        expR <= '0;
        arrR <= '0;
      end else if (stb.markEn[s]) begin
        arrR <= arrR | markVec[s];
      end
    end
    assign expAll[s] = expR;
    assign arrAll[s] = arrR;
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) slotPending[s] = |(expAll[s] & ~arrAll[s]);
  end

  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      srcExpHit[k] = expAll[srcSlot[k*SLOT_W +: SLOT_W]][srcOp[k*OP_W +: OP_W]];
    end
  end

  always_comb begin
    lowerMask   = (opVec_t'(1) << qryOp) - opVec_t'(1);
    qryOwnClear = ~|(expAll[qrySlot] & ~arrAll[qrySlot] & lowerMask);
  end
endmodule

// File: rtl/strk_ctrl.sv
module strk_ctrl
  import strk_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dispValid,
  input  logic [SLOT_W-1:0]      dispSlot,
  input  logic                   flushValid,
  input  slotVec_t               flushMask,
  input  logic                   commitValid,
  input  logic [SLOT_W-1:0]      commitSlot,
  input  logic                   localValid,
  input  logic [SLOT_W-1:0]      localSlot,
  input  logic [OP_W-1:0]        localOpId,
  input  logic [NSRC-1:0]        srcValid,
  input  logic [NSRC*SLOT_W-1:0] srcSlot,
  input  logic [NSRC-1:0]        srcExpHit,
  input  slotVec_t               slotPending,
  input  logic [SLOT_W-1:0]      qrySlot,
  input  logic                   qryOwnClear,
  output strobe_t                stb,
  output slotVec_t               donePulse,
  output logic                   qryClear,
  output logic                   errFlag,
  output logic                   bcastValid,
  output logic [SLOT_W-1:0]      bcastSlot,
  output logic [OP_W-1:0]        bcastOpId
);
  slotVec_t validQ, doneSentQ;
  slotVec_t dispHot, dropHot, fire;
  logic [SLOTS-1:0][SLOTS-1:0] olderQ;  // row s: slots dispatched before s
  logic srcBad;

  always_comb begin
    dispHot = dispValid ? (slotVec_t'(1) << dispSlot) : '0;
    dropHot = (flushValid ? flushMask : '0) |
              (commitValid ? (slotVec_t'(1) << commitSlot) : '0);
    stb.load   = dispHot;
    stb.drop   = dropHot;
    stb.markEn = validQ & ~dropHot & ~dispHot;
    fire = validQ & ~slotPending & ~doneSentQ & ~dispHot & ~dropHot;
  end

  always_comb begin
    srcBad = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (srcValid[k] && (!validQ[srcSlot[k*SLOT_W +: SLOT_W]] || !srcExpHit[k])) srcBad = 1'b1;
    end
  end

  always_comb begin
    qryClear = validQ[qrySlot] & qryOwnClear &
               ~|(olderQ[qrySlot] & validQ & slotPending);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ     <= '0;
      doneSentQ  <= '0;
      donePulse  <= '0;
      olderQ     <= '0;
      errFlag    <= 1'b0;
      bcastValid <= 1'b0;
      bcastSlot  <= '0;
      bcastOpId  <= '0;
    end else begin
      donePulse  <= fire;
      errFlag    <= errFlag | srcBad;
      bcastValid <= localValid;
      bcastSlot  <= localSlot;
      bcastOpId  <= localOpId;
      validQ     <= (validQ & ~dropHot) | dispHot;
      doneSentQ  <= (doneSentQ | fire) & ~dropHot & ~dispHot;
      for (int s = 0; s < SLOTS; s++) begin
        if (dispHot[s]) olderQ[s] <= validQ & ~dropHot & ~dispHot;
        else            olderQ[s] <= olderQ[s] & ~dispHot;
      end
    end
  end
endmodule

// File: rtl/store_done_tracker.sv
module store_done_tracker
  import strk_pkg::*;
#(
  parameter int NUM_PEERS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        dispValid,
  input  logic [SLOT_W-1:0]           dispSlot,
  input  logic [OPS-1:0]              dispMask,
  input  logic                        localValid,
  input  logic [SLOT_W-1:0]           localSlot,
  input  logic [OP_W-1:0]             localOpId,
  input  logic [NUM_PEERS-1:0]        peerValid,
  input  logic [NUM_PEERS*SLOT_W-1:0] peerSlot,
  input  logic [NUM_PEERS*OP_W-1:0]   peerOpId,
  input  logic                        flushValid,
  input  logic [SLOTS-1:0]            flushMask,
  input  logic                        commitValid,
  input  logic [SLOT_W-1:0]           commitSlot,
  input  logic [SLOT_W-1:0]           qrySlot,
  input  logic [OP_W-1:0]             qryOpId,
  output logic                        bcastValid,
  output logic [SLOT_W-1:0]           bcastSlot,
  output logic [OP_W-1:0]             bcastOpId,
  output logic [SLOTS-1:0]            donePulse,
  output logic                        qryClear,
  output logic                        errFlag
);
  localparam int NSRC = NUM_PEERS + 1;

  logic [NSRC-1:0]        srcValid;
  logic [NSRC*SLOT_W-1:0] srcSlot;
  logic [NSRC*OP_W-1:0]   srcOp;
  logic [NSRC-1:0]        srcExpHit;
  slotVec_t               slotPending;
  logic                   qryOwnClear;
  strobe_t                stb;

  // Source 0 is the local port, sources 1.. are the peer ports
  assign srcValid = {peerValid, localValid};
  assign srcSlot  = {peerSlot, localSlot};
  assign srcOp    = {peerOpId, localOpId};

  strk_ctrl #(.NSRC(NSRC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispSlot(dispSlot),
    .flushValid(flushValid), .flushMask(flushMask),
    .commitValid(commitValid), .commitSlot(commitSlot),
    .localValid(localValid), .localSlot(localSlot), .localOpId(localOpId),
    .srcValid(srcValid), .srcSlot(srcSlot), .srcExpHit(srcExpHit),
    .slotPending(slotPending), .qrySlot(qrySlot), .qryOwnClear(qryOwnClear),
    .stb(stb), .donePulse(donePulse), .qryClear(qryClear), .errFlag(errFlag),
    .bcastValid(bcastValid), .bcastSlot(bcastSlot), .bcastOpId(bcastOpId)
  );

  strk_data #(.NSRC(NSRC)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .dispMask(dispMask),
    .srcValid(srcValid), .srcSlot(srcSlot), .srcOp(srcOp),
    .qrySlot(qrySlot), .qryOp(qryOpId),
    .slotPending(slotPending), .srcExpHit(srcExpHit), .qryOwnClear(qryOwnClear)
  );
endmodule

// File: rtl/strk_chk.sv
module strk_chk
  import strk_pkg::*;
#(
  parameter int NUM_PEERS = 3
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        dispValid,
  input logic [SLOT_W-1:0]           dispSlot,
  input logic [OPS-1:0]              dispMask,
  input logic                        localValid,
  input logic [SLOT_W-1:0]           localSlot,
  input logic [OP_W-1:0]             localOpId,
  input logic [NUM_PEERS-1:0]        peerValid,
  input logic [NUM_PEERS*SLOT_W-1:0] peerSlot,
  input logic [NUM_PEERS*OP_W-1:0]   peerOpId,
  input logic                        flushValid,
  input logic [SLOTS-1:0]            flushMask,
  input logic                        commitValid,
  input logic [SLOT_W-1:0]           commitSlot,
  input logic [SLOT_W-1:0]           qrySlot,
  input logic [OP_W-1:0]             qryOpId,
  input logic                        bcastValid,
  input logic [SLOT_W-1:0]           bcastSlot,
  input logic [OP_W-1:0]             bcastOpId,
  input logic [SLOTS-1:0]            donePulse,
  input logic                        qryClear,
  input logic                        errFlag
);
  slotVec_t firedQ;  // slot has pulsed since its last dispatch

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) firedQ <= '0;
    else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (dispValid && dispSlot == SLOT_W'(s)) firedQ[s] <= 1'b0;
        else if (donePulse[s])                   firedQ[s] <= 1'b1;
      end
    end
  end

  AST_BCAST_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    localValid |=> bcastValid && bcastSlot == $past(localSlot) && bcastOpId == $past(localOpId)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R8

  AST_NO_PULSE_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispMask != '0) |=> !donePulse[$past(dispSlot)]); // R2

  AST_NO_PULSE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !(dispValid && dispSlot == commitSlot)) |=> !donePulse[$past(commitSlot)]); // R9

  for (genvar s = 0; s < SLOTS; s++) begin : gSlotChk
    AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
      donePulse[s] |-> !firedQ[s]); // R6

    AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      (flushValid && flushMask[s] && !(dispValid && dispSlot == SLOT_W'(s))) |=> !donePulse[s]); // R7
  end
endmodule

bind store_done_tracker strk_chk #(.NUM_PEERS(NUM_PEERS)) uChk (.*);

// File: tb/store_done_tracker_test.sv
module store_done_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rstN;
  logic dispValid; logic [2:0] dispSlot; logic [31:0] dispMask;
  logic localValid; logic [2:0] localSlot; logic [4:0] localOpId;
  logic [NP-1:0] peerValid; logic [NP*3-1:0] peerSlot; logic [NP*5-1:0] peerOpId;
  logic flushValid; logic [7:0] flushMask;
  logic commitValid; logic [2:0] commitSlot;
  logic [2:0] qrySlot; logic [4:0] qryOpId;
  logic bcastValid; logic [2:0] bcastSlot; logic [4:0] bcastOpId;
  logic [7:0] donePulse; logic qryClear; logic errFlag;

  int nChecks = 0;
  int nErrors = 0;

  // Bench model of the requirements
  logic [31:0] expM [8];
  logic [31:0] arrM [8];
  bit validM [8];
  bit doneM [8];
  int seqM [8];
  int seqCnt;
  bit errM;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_done_tracker #(.NUM_PEERS(NP)) uut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispSlot(dispSlot), .dispMask(dispMask),
    .localValid(localValid), .localSlot(localSlot), .localOpId(localOpId),
    .peerValid(peerValid), .peerSlot(peerSlot), .peerOpId(peerOpId),
    .flushValid(flushValid), .flushMask(flushMask),
    .commitValid(commitValid), .commitSlot(commitSlot),
    .qrySlot(qrySlot), .qryOpId(qryOpId),
    .bcastValid(bcastValid), .bcastSlot(bcastSlot), .bcastOpId(bcastOpId),
    .donePulse(donePulse), .qryClear(qryClear), .errFlag(errFlag)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit pendM(int s);
    return (expM[s] & ~arrM[s]) != 32'h0;
  endfunction

  function automatic bit qryModel(int qs, int k);
    logic [31:0] lower;
    if (!validM[qs]) return 1'b0;
    lower = (32'h1 << k) - 32'h1;
    if (((expM[qs] & ~arrM[qs]) & lower) != 32'h0) return 1'b0;
    for (int j = 0; j < 8; j++)
      if (j != qs && validM[j] && seqM[j] < seqM[qs] && pendM(j)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic idle();
    dispValid = 0; localValid = 0; peerValid = '0; flushValid = 0; commitValid = 0;
  endtask

  task automatic dispatch(int s, logic [31:0] m);
    dispValid = 1; dispSlot = 3'(s); dispMask = m;
  endtask

  task automatic localSt(int s, int op);
    localValid = 1; localSlot = 3'(s); localOpId = 5'(op);
  endtask

  task automatic peer(int p, int s, int op);
    peerValid[p] = 1'b1; peerSlot[p*3 +: 3] = 3'(s); peerOpId[p*5 +: 5] = 5'(op);
  endtask

  task automatic applySrc(bit v, int sl, int op, logic [7:0] loadH, logic [7:0] dropH, ref bit eX);
    if (!v) return;
    if (!validM[sl] || !expM[sl][op]) eX = 1'b1;
    if (validM[sl] && !loadH[sl] && !dropH[sl]) arrM[sl][op] = 1'b1;
  endtask

  // One clock: predict, advance the model, then compare after the edge
  task automatic cycle(string tag);
    logic [7:0] pX, loadH, dropH;
    bit eX, bvX;
    logic [2:0] bsX; logic [4:0] boX;
    loadH = dispValid ? (8'(1) << dispSlot) : 8'h0;
    dropH = (flushValid ? flushMask : 8'h0) | (commitValid ? (8'(1) << commitSlot) : 8'h0);
    for (int s = 0; s < 8; s++)
      pX[s] = validM[s] && !pendM(s) && !doneM[s] && !loadH[s] && !dropH[s];
    eX = errM;
    applySrc(localValid, int'(localSlot), int'(localOpId), loadH, dropH, eX);
    for (int p = 0; p < NP; p++)
      applySrc(peerValid[p], int'(peerSlot[p*3 +: 3]), int'(peerOpId[p*5 +: 5]), loadH, dropH, eX);
    for (int s = 0; s < 8; s++) begin
      if (pX[s]) doneM[s] = 1'b1;
      if (dropH[s]) begin validM[s] = 0; expM[s] = '0; arrM[s] = '0; doneM[s] = 0; end
      if (loadH[s]) begin
        validM[s] = 1; expM[s] = dispMask; arrM[s] = '0; doneM[s] = 0;
        seqM[s] = seqCnt; seqCnt++;
      end
    end
    errM = eX;
    bvX = localValid; bsX = localSlot; boX = localOpId;
    @(posedge clk);
    @(negedge clk);
    check(tag, "donePulse", 32'(donePulse), 32'(pX));
    check(tag, "errFlag", 32'(errFlag), 32'(eX));
    check(tag, "bcastValid", 32'(bcastValid), 32'(bvX));
    if (bvX) begin
      check(tag, "bcastSlot", 32'(bcastSlot), 32'(bsX));
      check(tag, "bcastOpId", 32'(bcastOpId), 32'(boX));
    end
    idle();
  endtask

  task automatic qcheck(string tag, int qs, int k);
    qrySlot = 3'(qs); qryOpId = 5'(k);
    #1;
    check(tag, "qryClear", 32'(qryClear), 32'(qryModel(qs, k)));
  endtask

  task automatic doReset();
    idle();
    rstN = 0;
    for (int s = 0; s < 8; s++) begin
      expM[s] = '0; arrM[s] = '0; validM[s] = 0; doneM[s] = 0; seqM[s] = 0;
    end
    seqCnt = 0; errM = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  function automatic int pickOp(int s);
    logic [31:0] o;
    int st;
    o = expM[s] & ~arrM[s];
    if (o == 32'h0 || ($urandom % 400) == 0) return int'($urandom % 32);
    st = int'($urandom % 32);
    for (int i = 0; i < 32; i++) if (o[(st + i) % 32]) return (st + i) % 32;
    return 0;
  endfunction

  function automatic int pickValid();
    int s;
    for (int t = 0; t < 16; t++) begin
      s = int'($urandom % 8);
      if (validM[s]) return s;
    end
    return -1;
  endfunction

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    int dummy;
    dummy = int'($urandom(1234));
    dispSlot = 0; dispMask = 0; localSlot = 0; localOpId = 0;
    peerSlot = '0; peerOpId = '0; flushMask = 0; commitSlot = 0;
    qrySlot = 0; qryOpId = 0;
    doReset();

    // R1: reset state
    check("R1", "donePulse", 32'(donePulse), 32'h0);
    check("R1", "errFlag", 32'(errFlag), 32'h0);
    check("R1", "bcastValid", 32'(bcastValid), 32'h0);
    for (int s = 0; s < 8; s++) qcheck("R1", s, 31);

    // R2: empty mask completes one cycle after dispatch, R6: only once
    dispatch(0, 32'h0); cycle("R2");
    cycle("R2");
    cycle("R6");

    // R3 local then R4 peer completes a two-store block, R5 pulse timing
    dispatch(1, 32'h0000_0088); cycle("R2");
    qcheck("R10", 1, 8);
    qcheck("R10", 1, 3);
    localSt(1, 3); cycle("R3");
    qcheck("R10", 1, 8);
    qcheck("R10", 1, 7);
    peer(0, 1, 7); cycle("R4");
    cycle("R5");
    peer(1, 1, 3); cycle("R6");
    cycle("R6");

    // R4 all ports in one cycle, R11 slot independence, R10 older blocking
    dispatch(2, 32'h0000_0107); cycle("R2");
    dispatch(3, 32'h0000_0024); cycle("R2");
    peer(0, 2, 0); peer(1, 3, 2); peer(2, 2, 1); localSt(2, 8); cycle("R4");
    qcheck("R10", 3, 0);
    peer(2, 2, 2); cycle("R11");
    cycle("R11");
    qcheck("R10", 3, 0);
    qcheck("R10", 3, 6);

    // R7 flush of a pending older block unblocks a younger one
    dispatch(4, 32'h0000_0001); cycle("R2");
    qcheck("R10", 4, 0);
    flushValid = 1; flushMask = 8'h08; cycle("R7");
    qcheck("R7", 4, 0);
    qcheck("R7", 3, 0);
    cycle("R7");
    // R7 flush and dispatch of the same slot: dispatch wins
    flushValid = 1; flushMask = 8'h10; dispatch(4, 32'h0); cycle("R7");
    cycle("R7");

    // R9 commit deallocates
    commitValid = 1; commitSlot = 3'd1; cycle("R9");
    qcheck("R9", 1, 0);
    cycle("R9");

    // R8 unexpected ID on a valid slot is ignored and flagged
    dispatch(6, 32'h0000_0003); cycle("R2");
    localSt(6, 20); cycle("R8");
    qcheck("R8", 6, 31);
    peer(0, 6, 0); peer(1, 6, 1); cycle("R8");
    cycle("R8");

    // R9 notification to a committed slot raises the error
    doReset();
    dispatch(5, 32'h0000_0002); cycle("R2");
    localSt(5, 1); cycle("R3");
    cycle("R5");
    commitValid = 1; commitSlot = 3'd5; cycle("R9");
    peer(2, 5, 1); cycle("R9");
    cycle("R9");

    // Seeded random traffic
    doReset();
    for (int it = 0; it < 4000; it++) begin
      int s, r;
      r = int'($urandom % 100);
      if (r < 15) begin
        s = int'($urandom % 8);
        for (int t = 0; t < 8 && validM[s]; t++) s = int'($urandom % 8);
        if (($urandom % 8) == 0) dispatch(s, 32'h0);
        else dispatch(s, $urandom & $urandom & $urandom);
      end
      if (($urandom % 2) == 0) begin
        s = pickValid();
        if (s >= 0) localSt(s, pickOp(s));
      end
      for (int p = 0; p < NP; p++) begin
        if (($urandom % 10) < 3) begin
          s = pickValid();
          if (s >= 0) peer(p, s, pickOp(s));
        end
      end
      if (($urandom % 100) < 3) begin
        flushValid = 1;
        flushMask = (($urandom % 2) == 0) ? (8'(1) << ($urandom % 8)) : 8'($urandom);
      end
      if (($urandom % 100) < 8) begin
        s = int'($urandom % 8);
        if (validM[s] && doneM[s]) begin commitValid = 1; commitSlot = 3'(s); end
      end
      qcheck("R10 random", int'($urandom % 8), int'($urandom % 32));
      cycle("R5 R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule